// File: doc/BRIEF.md
# Serial Interface Status Flag Arm-and-Clear Controller

This block keeps the nine event flags of an asynchronous serial port and controls how bus software clears them. The transmitter and receiver raise flags with one-cycle set pulses. Software cannot clear a flag by writing to it. It clears flags in two steps. First it reads the status register, which captures an arm mask of every flag set at that instant. Then it accesses the data register. A read of the data register drops the armed receive-side flags. A write to the data register drops the armed transmit-side flags. A flag raised between the two steps is not in the mask, so it survives.

The bus sees two adjacent 16-bit registers: status at byte offsets 0 and 1, data at offsets 2 and 3. Accesses can be a byte, a half-word, or a 32-bit word at offset 0 that covers both registers. A word read returns status in the upper half and data in the lower half. In that one access it also clears the receive flags that were set when the read happened. The data register reads the receiver's current character. Writes to it are passed to the transmitter.

Top module: `sci_flag_ctl`

## Requirements
- R1: After reset the status register reads 0x0180 (transmit-empty and transmit-complete set, all else clear). Status bits 15..9 always read as zero.
- R2: Each bit of `set_evt` makes its flag read as 1 after the next clock edge, whatever the bus does in that cycle. Flag bit positions within the status register: 8 transmit-empty, 7 transmit-complete, 6 receive-full, 5 receiver-active, 4 idle, 3 overrun, 2 noise, 1 framing, 0 parity.
- R3: A status read arms all flags set in that cycle. The read may be a byte at offset 0 or 1, or a half-word at offset 0. Encodings: `bus_size` 0 byte, 1 half-word, 2 word; `bus_addr` is the byte offset. A later data read clears the armed receive flags (bits 6..0). That data read is a byte at offset 3 or a half-word at offset 2.
- R4: Armed transmit flags (bits 8, 7) are cleared only by a data write. That write is a byte at offset 3, a half-word at offset 2, or a word at offset 0. A data read leaves these flags unchanged.
- R5: A flag set after the arming status read survives the following data access.
- R6: A data access clears nothing unless an earlier status read armed the flag. The access consumes the arm bits of the kind it clears.
- R7: Writes to the status register (byte at offset 0 or 1, half-word at offset 0, any data) never change a flag.
- R8: A word read at offset 0 returns {status, data}. It clears the receive flags that were set during that cycle and leaves bits 8 and 7 set. Those two flags stay armed for a later data write.
- R9: Byte accesses at offset 2 (the upper data byte) neither clear nor consume arm bits.
- R10: When a set pulse and a clear hit the same flag in one cycle, the flag stays 1.
- R11: `bus_rdata[15:0]` always equals `rx_data`, and `bus_rdata[31:16]` equals the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word |
| bus_addr | input | 2 | Byte offset of the access |
| bus_wdata | input | 16 | Write data (a word write uses it as the data half) |
| bus_rdata | output | 32 | {status, data} read view |
| set_evt | input | 9 | Flag set pulses, bit order as in R2 |
| rx_data | input | 16 | Receiver character shown as the data register |
| tx_load | output | 1 | Data-register write strobe toward the transmitter |
| tx_data | output | 16 | Data written to the data register |

## Verification
The hardest case to reach is a set pulse that lands between an arming status read and the data access that consumes the mask. A set pulse on the same edge as that consuming access is also hard, and so is a word read that arms and clears in one cycle. The stimulus table pulses `set_evt` in the idle cycle between a status read and a data read. Directed steps put a set pulse in the same cycle as a word read and as a data read. After each step the flags that must survive are checked.

// File: rtl/sci_flag_pkg.sv
package sci_flag_pkg;
  localparam int NFLAG = 9;

  typedef logic [NFLAG-1:0] flag_t;

  // transmit-side flags: bits 8 (empty) and 7 (complete)
  localparam flag_t TX_MASK     = 9'h180;
  localparam flag_t RX_MASK     = 9'h07F;
  localparam flag_t RESET_FLAGS = 9'h180;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic stat_rd;
    logic word_rd;
    logic data_rd;
    logic data_wr;
  } acc_dec_t;
endpackage

// File: rtl/sci_acc_decode.sv
module sci_acc_decode
  import sci_flag_pkg::*;
(
  input  logic       valid,
  input  logic       write,
  input  logic [1:0] size,
  input  logic [1:0] addr,
  output acc_dec_t   dec
);
  logic is_byte, is_half, is_word;
  logic hit_stat, hit_data_lo, word0;

  always_comb begin
    is_byte     = (size == SZ_BYTE);
    is_half     = (size == SZ_HALF);
    is_word     = (size == SZ_WORD);
    word0       = is_word && (addr == 2'd0);
    hit_stat    = (is_byte && !addr[1]) || (is_half && addr == 2'd0) || word0;
    hit_data_lo = (is_byte && addr == 2'd3) || (is_half && addr == 2'd2) || word0;

    dec.stat_rd = valid && !write && hit_stat;
    dec.word_rd = valid && !write && word0;
    dec.data_rd = valid && !write && hit_data_lo;
    dec.data_wr = valid &&  write && hit_data_lo;
  end
endmodule

// File: rtl/sci_arm_clear.sv
module sci_arm_clear
  import sci_flag_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  acc_dec_t dec,
  input  flag_t    flags,
  output flag_t    clr
);
  flag_t arm_q, arm_nxt;
  logic  arm_en;

  always_comb begin
    arm_nxt = arm_q;
    clr     = '0;
    if (dec.data_rd) begin
      clr     = clr | (arm_q & RX_MASK);
      arm_nxt = arm_nxt & ~RX_MASK;
    end
    if (dec.data_wr) begin
      clr     = clr | (arm_q & TX_MASK);
      arm_nxt = arm_nxt & ~TX_MASK;
    end
    if (dec.stat_rd) begin
      arm_nxt = flags;
    end
    if (dec.word_rd) begin
      clr     = clr | (flags & RX_MASK);
      arm_nxt = flags & TX_MASK;
    end
    arm_en = dec.stat_rd || dec.data_rd || dec.data_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= '0;
    else if (arm_en) arm_q <= arm_nxt;
  end
endmodule

// File: rtl/sci_flag_bank.sv
module sci_flag_bank
  import sci_flag_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  flag_t set,
  input  flag_t clr,
  output flag_t flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic q, d, en;

    always_comb begin
      en = set[i] || clr[i];
      d  = set[i] || (q && !clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RESET_FLAGS[i];
      else if (en) q <= d;
    end

    assign flags[i] = q;
  end
endmodule

// File: rtl/sci_flag_ctl.sv
module sci_flag_ctl
  import sci_flag_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [1:0]      bus_size,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [2*DW-1:0] bus_rdata,
  input  logic [8:0]      set_evt,
  input  logic [DW-1:0]   rx_data,
  output logic            tx_load,
  output logic [DW-1:0]   tx_data
);
  localparam int PAD = DW - NFLAG;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_core_n;
  acc_dec_t               dec;
  flag_t                  flags, clr;
  logic [DW-1:0]          status_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = sync_q[SYNC_STAGES-1];

  sci_acc_decode u_dec (
    .valid (bus_valid),
    .write (bus_write),
    .size  (bus_size),
    .addr  (bus_addr),
    .dec   (dec)
  );

  sci_arm_clear u_arm (
    .clk   (clk),
    .rst_n (rst_core_n),
    .dec   (dec),
    .flags (flags),
    .clr   (clr)
  );

  sci_flag_bank u_bank (
    .clk   (clk),
    .rst_n (rst_core_n),
    .set   (set_evt),
    .clr   (clr),
    .flags (flags)
  );

  always_comb begin
    status_w  = {{PAD{1'b0}}, flags};
    bus_rdata = {status_w, rx_data};
    tx_load   = dec.data_wr;
    tx_data   = bus_wdata;
  end
endmodule

// File: rtl/sci_flag_chk.sv
module sci_flag_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [1:0]    bus_size,
  input logic [1:0]    bus_addr,
  input logic [8:0]    set_evt,
  input logic [DW-1:0] status,
  input logic          data_rd,
  input logic          data_wr
);
  logic       past_ok;
  logic [8:0] fl;
  logic       stat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assign fl      = status[8:0];
  assign stat_wr = bus_valid && bus_write && (bus_size != 2'd2) && !bus_addr[1];

  // R1
  r1_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[DW-1:9] == '0);

  // R2
  r2_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && |set_evt) |=> ((fl & $past(set_evt)) == $past(set_evt)));

  // R7
  r7_stat_wr_no_eff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && stat_wr && set_evt == '0 && !data_rd && !data_wr) |=> (fl == $past(fl)));

  // R4
  r4_tx_fall_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && |($past(fl[8:7]) & ~fl[8:7])) |-> $past(data_wr));

  // R6
  r6_fall_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && |($past(fl) & ~fl)) |-> ($past(data_rd) || $past(data_wr)));
endmodule

bind sci_flag_ctl sci_flag_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_size  (bus_size),
  .bus_addr  (bus_addr),
  .set_evt   (set_evt),
  .status    (status_w),
  .data_rd   (dec.data_rd),
  .data_wr   (dec.data_wr)
);

// File: tb/sim_sci_flag_ctl.sv
`timescale 1ns/1ps
module sim_sci_flag_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [1:0]  bus_size, bus_addr;
  logic [15:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [8:0]  set_evt;
  logic [15:0] rx_data;
  logic        tx_load;
  logic [15:0] tx_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sci_flag_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .set_evt(set_evt), .rx_data(rx_data),
    .tx_load(tx_load), .tx_data(tx_data)
  );

  // {set[8:0], valid, write, size[1:0], addr[1:0], expected status[15:0]}
  localparam int NV = 18;
  localparam logic [30:0] VEC [NV] = '{
    {9'h042, 1'b0, 1'b0, 2'd0, 2'd0, 16'h01C2}, // R2 set receive-full + framing
    {9'h000, 1'b1, 1'b0, 2'd1, 2'd2, 16'h01C2}, // R6 data read, nothing armed
    {9'h000, 1'b1, 1'b0, 2'd1, 2'd0, 16'h01C2}, // R3 arming half read
    {9'h008, 1'b0, 1'b0, 2'd0, 2'd0, 16'h01CA}, // R5 overrun after arming
    {9'h000, 1'b1, 1'b0, 2'd1, 2'd2, 16'h0188}, // R3 R5 data read clears armed rx
    {9'h000, 1'b1, 1'b0, 2'd1, 2'd2, 16'h0188}, // R6 arm consumed
    {9'h000, 1'b1, 1'b0, 2'd0, 2'd1, 16'h0188}, // R3 lower status byte arms
    {9'h000, 1'b1, 1'b1, 2'd1, 2'd2, 16'h0008}, // R4 data write clears tx flags
    {9'h000, 1'b1, 1'b0, 2'd0, 2'd3, 16'h0000}, // R3 lower data byte read
    {9'h185, 1'b0, 1'b0, 2'd0, 2'd0, 16'h0185}, // R2
    {9'h000, 1'b1, 1'b0, 2'd0, 2'd0, 16'h0185}, // R3 upper status byte arms all
    {9'h000, 1'b1, 1'b0, 2'd0, 2'd2, 16'h0185}, // R9 upper data byte read
    {9'h000, 1'b1, 1'b1, 2'd0, 2'd2, 16'h0185}, // R9 upper data byte write
    {9'h000, 1'b1, 1'b1, 2'd0, 2'd3, 16'h0005}, // R4 lower data byte write
    {9'h000, 1'b1, 1'b1, 2'd1, 2'd0, 16'h0005}, // R7 status half write of zero
    {9'h000, 1'b1, 1'b1, 2'd0, 2'd0, 16'h0005}, // R7 status upper byte write
    {9'h000, 1'b1, 1'b1, 2'd0, 2'd1, 16'h0005}, // R7 status lower byte write
    {9'h000, 1'b1, 1'b0, 2'd1, 2'd2, 16'h0000}  // R3 arm held across other accesses
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_bus();
    bus_valid = 1'b0; bus_write = 1'b0; bus_size = 2'd0; bus_addr = 2'd0;
    bus_wdata = 16'h0000; set_evt = '0;
  endtask

  // drive for one edge, then release and leave time for sampling
  task automatic op(input logic [8:0] s, input logic v, input logic w,
                    input logic [1:0] sz, input logic [1:0] ad);
    set_evt = s; bus_valid = v; bus_write = w; bus_size = sz; bus_addr = ad;
    @(posedge clk);
    #2;
    idle_bus();
  endtask

  task automatic do_reset();
    idle_bus();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rx_data = 16'hA5C3;
    do_reset();
    check("R1 reset status", {16'h0, bus_rdata[31:16]}, 32'h0000_0180);
    check("R11 data view", {16'h0, bus_rdata[15:0]}, 32'h0000_A5C3);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][30:22], VEC[i][21], VEC[i][20], VEC[i][19:18], VEC[i][17:16]);
      check($sformatf("vector %0d (R2-R9)", i), {16'h0, bus_rdata[31:16]}, {16'h0, VEC[i][15:0]});
    end

    // R8: word read clears rx flags set at read; late parity survives (R5)
    op(9'h0D0, 1'b0, 1'b0, 2'd0, 2'd0);
    check("R2 preset", {16'h0, bus_rdata[31:16]}, 32'h0000_00D0);
    rx_data = 16'h3C5A;
    set_evt = 9'h001; bus_valid = 1'b1; bus_write = 1'b0; bus_size = 2'd2; bus_addr = 2'd0;
    #1;
    check("R8 word read view", bus_rdata, 32'h00D0_3C5A);
    @(posedge clk); #2; idle_bus();
    check("R8 rx cleared, tx kept", {16'h0, bus_rdata[31:16]}, 32'h0000_0081);
    op(9'h000, 1'b1, 1'b0, 2'd1, 2'd2);
    check("R4 data read leaves tx", {16'h0, bus_rdata[31:16]}, 32'h0000_0081);
    bus_wdata = 16'h0055;
    set_evt = '0; bus_valid = 1'b1; bus_write = 1'b1; bus_size = 2'd1; bus_addr = 2'd2;
    #1;
    check("R4 tx_load strobe", {15'h0, tx_load, tx_data}, {15'h0, 1'b1, 16'h0055});
    @(posedge clk); #2; idle_bus();
    check("R8 word-armed tx cleared by write", {16'h0, bus_rdata[31:16]}, 32'h0000_0001);

    // R10: set and clear on same edge
    op(9'h000, 1'b1, 1'b0, 2'd1, 2'd0);
    op(9'h001, 1'b1, 1'b0, 2'd1, 2'd2);
    check("R10 set wins", {16'h0, bus_rdata[31:16]}, 32'h0000_0001);
    op(9'h000, 1'b1, 1'b0, 2'd1, 2'd2);
    check("R6 consumed arm", {16'h0, bus_rdata[31:16]}, 32'h0000_0001);

    // R2: set during a status write
    op(9'h020, 1'b1, 1'b1, 2'd1, 2'd0);
    check("R2 set during bus write", {16'h0, bus_rdata[31:16]}, 32'h0000_0021);
    check("R11 data view follows rx", {16'h0, bus_rdata[15:0]}, 32'h0000_3C5A);

    // R1: reset in mid-run
    do_reset();
    check("R1 re-reset status", bus_rdata, 32'h0180_3C5A);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule